// File: doc/BRIEF.md
# Serial Converter Capture Controller

This block is the host-side master for a 16-bit sampling converter that is read over a three-wire synchronous serial port. A one-cycle start strobe begins a frame. The block pulls chip select low and divides the fast system clock into a data clock. It then skips the converter's sample window and captures the serial data on each rising data-clock edge. The converter launches each bit on the falling edge. Once the frame closes, the block presents the result word together with a one-cycle valid pulse and an error flag.

The caller sets three values for each frame: the half-period of the data clock in system clocks, the number of result bits to read, and whether to check the replay. When the bit count is short, the frame ends early. This saves clocks and power, and the unread low bits are reported as zero. When the replay check is on and the full word is read, the block keeps clocking while the converter repeats the word least significant bit first. It compares that copy with the word read most significant bit first.

Top module: `adc_capture_ctrl`

## Requirements
- R1: After reset, cs_n is 1 and sclk, busy, valid, result and err are all 0.
- R2: A start seen while idle drives cs_n low on the next clock, and busy rises with it. sclk stays low for at least one system clock after cs_n falls. busy stays high until the cycle after valid and drops in the cycle that follows it.
- R3: During a frame, every sclk high phase lasts exactly H system clocks, and so does every sclk low phase that ends in a rising edge (including the first one after cs_n falls). H is half_div, and a half_div of 0 counts as 1.
- R4: sdata is captured at each rising sclk edge. Rises 1 to 5 are the sample window and are discarded. Rise 6 carries the null bit. Rises 7 onward carry the result most significant bit first, loaded from result bit 15 downward. Result bits that were not read are 0.
- R5: A null bit that reads 1 sets err for that frame.
- R6: N is nbits, and a value of 0 or above 16 means 16. A frame makes exactly 6+N rising sclk edges, plus 15 more when the replay check applies. cs_n rises one system clock after the last falling sclk edge.
- R7: When replay_en is 1 and N is 16, rises 23 to 37 capture result bits 1, 2, …, 15 in that order. Any difference from the word read first sets err. When N is below 16, replay_en has no effect on the edge count or on err.
- R8: valid is high for exactly one clock per frame, in the same cycle that cs_n rises. result and err change only in that cycle and hold until the next one.
- R9: A start that arrives while busy is high is ignored. The frame runs its normal edge count, and no second frame follows it.
- R10: sclk is never high while cs_n is high, and cs_n rises only when sclk has been low for the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a frame |
| half_div | input | DIV_W | Data-clock half-period in system clocks (0 counts as 1) |
| nbits | input | NB_W | Result bits to read, 1 to 16; 0 or above 16 means 16 |
| replay_en | input | 1 | Check the least-significant-first repeat against the word |
| sdata | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Data clock to the converter |
| busy | output | 1 | Frame in progress |
| valid | output | 1 | One-cycle pulse when result and err are updated |
| result | output | RES_W | Captured word, zero-filled below the bits read |
| err | output | 1 | Null bit was high, or the replay disagreed |

## Verification
The bench sweeps every bit count from 0 to 17 across four divider settings, with the replay check both on and off. A design with an off-by-one in the bit count, or that mishandles the 0 and over-range codes, would end the frame at the wrong rising edge or misplace the zero fill. The behavioural converter drives a 1 during the sample window. A capture index shifted by one would therefore read that 1 as the null bit and raise a false error, or would shift the word by one bit. Replay corruption is injected at both the lowest and the highest replay position, and also while a short frame is selected. This catches a comparison that is misaligned, incomplete, or not gated by the bit count. Start strobes issued in the middle of a frame show whether a design restarts or chains a second frame.

// File: rtl/adc_capture_pkg.sv
// Shared types and frame constants for the serial converter capture controller.
// Assumes the converter spends a fixed number of data-clock periods sampling
// before it drives the null bit.
package adc_capture_pkg;

    // Rising data-clock edges that fall inside the sample window
    localparam int SAMPLE_RISES = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } frame_st_t;

endpackage

// File: rtl/adc_sclk_gen.sv
// Data-clock divider. While run is high it toggles sclk every half_eff system
// clocks, starting low. rise_now and fall_now flag the cycle whose closing edge
// makes sclk rise or fall, so the capture logic samples sdata on that same edge.
// Assumes run drops only after a falling edge; dropping run forces sclk low.
module adc_sclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             sclk,
    output logic             rise_now,
    output logic             fall_now
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             tick;

    // Find the end of the current half-period and which edge it produces
    always_comb begin
        half_eff = (half_div == '0) ? DIV_W'(1) : half_div;
        tick     = run && (cnt == half_eff - DIV_W'(1));
        rise_now = tick && !sclk;
        fall_now = tick && sclk;
    end

    // Half-period counter and data-clock register
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (tick) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/adc_bit_capture.sv
// Serial capture. It sorts each sampled bit by its rising-edge index:
// the null bit, the most-significant-first word, and the least-significant-first
// replay of bits 1 and up. Both words are cleared when a frame starts, so a
// short frame leaves zeros below the last bit read.
// Assumes rise_idx counts rising edges from 0 within the frame.
module adc_bit_capture #(
    parameter int RES_W      = 16,
    parameter int CNT_W      = 6,
    parameter int FIRST_DATA = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise_now,
    input  logic [CNT_W-1:0] rise_idx,
    input  logic             sdata,
    output logic [RES_W-1:0] word,
    output logic             null_bit,
    output logic             replay_diff
);

    localparam int NULL_IDX  = FIRST_DATA - 1;
    localparam int FIRST_REP = FIRST_DATA + RES_W;

    logic [RES_W-1:1] rep_word;

    // Place each captured bit by its edge index
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word     <= '0;
            rep_word <= '0;
            null_bit <= 1'b0;
        end else if (rise_now) begin
            if (rise_idx == CNT_W'(NULL_IDX)) begin
                null_bit <= sdata;
            end
            for (int b = 0; b < RES_W; b++) begin
                if (rise_idx == CNT_W'(FIRST_DATA + RES_W - 1 - b)) begin
                    word[b] <= sdata;
                end
            end
            for (int b = 1; b < RES_W; b++) begin
                if (rise_idx == CNT_W'(FIRST_REP + b - 1)) begin
                    rep_word[b] <= sdata;
                end
            end
        end
    end

    // Replay comparison over bits that the replay repeats
    always_comb begin
        replay_diff = (rep_word != word[RES_W-1:1]);
    end

endmodule

// File: rtl/adc_capture_ctrl.sv
// Frame controller for the serial converter port. A start strobe in idle
// latches the configuration and drops chip select. The controller then runs the
// data clock for a computed number of rising edges, and raises chip select one
// clock after the last falling edge. In that cycle it updates result and err and
// pulses valid. Assumes the caller keeps start low, or ignores it, while busy is high.
module adc_capture_ctrl
    import adc_capture_pkg::*;
#(
    parameter  int RES_W = 16,
    parameter  int DIV_W = 8,
    localparam int NB_W  = $clog2(RES_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic [NB_W-1:0]  nbits,
    input  logic             replay_en,
    input  logic             sdata,
    output logic             cs_n,
    output logic             sclk,
    output logic             busy,
    output logic             valid,
    output logic [RES_W-1:0] result,
    output logic             err
);

    localparam int FIRST_DATA = SAMPLE_RISES + 1;
    localparam int CNT_W      = $clog2(FIRST_DATA + 2 * RES_W);

    frame_st_t        st;
    logic [DIV_W-1:0] half_q;
    logic             rep_q;
    logic [CNT_W-1:0] rise_cnt;
    logic [CNT_W-1:0] total_q;
    logic [CNT_W-1:0] total_d;
    logic [NB_W-1:0]  n_eff;
    logic             rep_ok;
    logic             accept;
    logic             rise_now;
    logic             fall_now;
    logic [RES_W-1:0] word;
    logic             null_bit;
    logic             replay_diff;

    // Decode the bit count, the replay option and the frame length
    always_comb begin
        n_eff   = (nbits == '0 || nbits > NB_W'(RES_W)) ? NB_W'(RES_W) : nbits;
        rep_ok  = replay_en && (n_eff == NB_W'(RES_W));
        total_d = CNT_W'(FIRST_DATA) + CNT_W'(n_eff) + (rep_ok ? CNT_W'(RES_W - 1) : '0);
        accept  = (st == ST_IDLE) && !valid && start;
        busy    = (st != ST_IDLE) || valid;
    end

    adc_sclk_gen #(
        .DIV_W (DIV_W)
    ) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st == ST_RUN),
        .half_div (half_q),
        .sclk     (sclk),
        .rise_now (rise_now),
        .fall_now (fall_now)
    );

    adc_bit_capture #(
        .RES_W      (RES_W),
        .CNT_W      (CNT_W),
        .FIRST_DATA (FIRST_DATA)
    ) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (accept),
        .rise_now    (rise_now),
        .rise_idx    (rise_cnt),
        .sdata       (sdata),
        .word        (word),
        .null_bit    (null_bit),
        .replay_diff (replay_diff)
    );

    // Frame sequencing, chip select and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cs_n     <= 1'b1;
            valid    <= 1'b0;
            result   <= '0;
            err      <= 1'b0;
            rise_cnt <= '0;
            total_q  <= '0;
            half_q   <= '0;
            rep_q    <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        st       <= ST_RUN;
                        cs_n     <= 1'b0;
                        rise_cnt <= '0;
                        total_q  <= total_d;
                        half_q   <= half_div;
                        rep_q    <= rep_ok;
                    end
                end
                ST_RUN: begin
                    if (rise_now) begin
                        rise_cnt <= rise_cnt + CNT_W'(1);
                    end
                    if (fall_now && rise_cnt == total_q) begin
                        st <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    cs_n   <= 1'b1;
                    valid  <= 1'b1;
                    result <= word;
                    err    <= null_bit || (rep_q && replay_diff);
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_capture_ctrl_chk.sv
// Port-level protocol checker for adc_capture_ctrl, attached with bind.
// It checks chip-select and data-clock ordering, the valid pulse, result hold
// and start acceptance. It assumes a synchronous active-low reset.
module adc_capture_ctrl_chk #(
    parameter int RES_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             cs_n,
    input logic             sclk,
    input logic             busy,
    input logic             valid,
    input logic [RES_W-1:0] result,
    input logic             err
);

    // R10: the data clock only runs inside a frame
    assert_sclk_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R10: chip select rises only once the data clock has settled low
    assert_cs_rise_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (!sclk && !$past(sclk)));

    // R2: chip select was already low before any rising data-clock edge
    assert_cs_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> !$past(cs_n));

    // R2: busy covers the whole time chip select is low
    assert_busy_cover_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    // R8: valid lasts one cycle
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R8: valid comes with the chip-select rise, and never without it
    assert_valid_with_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));
    assert_cs_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> valid);

    // R8: result and err hold between valid pulses
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> ($stable(result) && $stable(err)));

    // R9: a frame begins only from idle with a start request
    assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> ($past(start) && !$past(busy)));

endmodule

bind adc_capture_ctrl adc_capture_ctrl_chk #(.RES_W(RES_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .cs_n   (cs_n),
    .sclk   (sclk),
    .busy   (busy),
    .valid  (valid),
    .result (result),
    .err    (err)
);

// File: tb/sim_adc_capture_ctrl.sv
// Bench for adc_capture_ctrl: a behavioural converter model plus sweeps over
// divider, bit count and replay option; expected values are computed here.
module sim_adc_capture_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  half_div = 8'd1;
    logic [4:0]  nbits = 5'd16;
    logic        replay_en = 1'b0;
    logic        sdata = 1'b1;
    logic        cs_n;
    logic        sclk;
    logic        busy;
    logic        valid;
    logic [15:0] result;
    logic        err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    adc_capture_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .half_div  (half_div),
        .nbits     (nbits),
        .replay_en (replay_en),
        .sdata     (sdata),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .busy      (busy),
        .valid     (valid),
        .result    (result),
        .err       (err)
    );

    // Converter model: null bit after fall 5, word MSB first, then LSB-first replay
    logic [15:0] m_word = '0;
    logic        m_null = 1'b0;
    int          m_cbit = 0;
    int          m_fcnt = 0;

    always @(negedge cs_n) begin
        m_fcnt = 0;
        sdata  = 1'b1;
    end

    always @(negedge sclk) begin
        if (cs_n === 1'b0) begin
            m_fcnt = m_fcnt + 1;
            if (m_fcnt < 5)       sdata = 1'b1;
            else if (m_fcnt == 5) sdata = m_null;
            else if (m_fcnt <= 21) sdata = m_word[21 - m_fcnt];
            else if (m_fcnt <= 36) sdata = m_word[m_fcnt - 21] ^ ((m_fcnt - 21) == m_cbit);
            else                  sdata = 1'b0;
        end
    end

    // Port monitor: edge count, phase lengths, chip-select ordering, valid count
    int h_exp = 1;
    int rises = 0, bad_hi = 0, bad_lo = 0, bad_cs = 0, vcnt = 0, run_len = 0;
    logic p_sclk = 1'b0, p_cs = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && cs_n) bad_cs++;
            if (cs_n && !p_cs && (sclk || p_sclk)) bad_cs++;
            if (valid) vcnt++;
            if (!cs_n) begin
                if (p_cs) begin
                    run_len = 1;
                    if (sclk) bad_cs++;
                end else if (sclk != p_sclk) begin
                    if (p_sclk) begin
                        if (run_len != h_exp) bad_hi++;
                    end else begin
                        rises++;
                        if (run_len != h_exp) bad_lo++;
                    end
                    run_len = 1;
                end else begin
                    run_len++;
                end
            end
            p_sclk = sclk;
            p_cs   = cs_n;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [15:0] prev_res = '0;

    task automatic run_frame(input logic [15:0] w, input int h, input int n, input bit rep,
                             input bit nullv, input int cbit, input bit poke);
        int          neff;
        int          exp_rises;
        logic [15:0] mask;
        logic [15:0] exp_res;
        logic        exp_err;
        neff      = (n == 0 || n > 16) ? 16 : n;
        mask      = 16'((32'hFFFF << (16 - neff)) & 32'hFFFF);
        exp_res   = w & mask;
        exp_err   = nullv | (rep && neff == 16 && cbit != 0);
        exp_rises = 6 + neff + ((rep && neff == 16) ? 15 : 0);
        m_word = w; m_null = nullv; m_cbit = cbit;
        half_div = 8'(h); nbits = 5'(n); replay_en = rep;
        h_exp = (h == 0) ? 1 : h;
        rises = 0; bad_hi = 0; bad_lo = 0; bad_cs = 0; vcnt = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R2 cs_n low after start", {31'd0, cs_n}, 32'd0);
        check("R2 busy after start", {31'd0, busy}, 32'd1);
        repeat (2) @(negedge clk);
        check("R8 result held mid-frame", {16'd0, result}, {16'd0, prev_res});
        if (poke) begin
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (!valid) @(negedge clk);
        check("R4 R6 result word", {16'd0, result}, {16'd0, exp_res});
        check("R5 R7 err flag", {31'd0, err}, {31'd0, exp_err});
        check("R2 busy at valid", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R2 busy released", {31'd0, busy}, 32'd0);
        check("R8 valid one cycle", {31'd0, valid}, 32'd0);
        repeat (3) @(negedge clk);
        check("R9 no extra frame", {31'd0, cs_n}, 32'd1);
        check("R8 valid count", 32'(vcnt), 32'd1);
        check("R6 R7 rising edges", 32'(rises), 32'(exp_rises));
        check("R3 high phases", 32'(bad_hi), 32'd0);
        check("R3 low phases", 32'(bad_lo), 32'd0);
        check("R10 cs and sclk order", 32'(bad_cs), 32'd0);
        prev_res = exp_res;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", {31'd0, cs_n}, 32'd1);
        check("R1 sclk", {31'd0, sclk}, 32'd0);
        check("R1 busy", {31'd0, busy}, 32'd0);
        check("R1 valid", {31'd0, valid}, 32'd0);
        check("R1 result", {16'd0, result}, 32'd0);
        check("R1 err", {31'd0, err}, 32'd0);

        // R3 R4 R6 R7 sweep over divider, bit count and replay option
        for (int h = 0; h < 4; h++) begin
            for (int n = 0; n < 18; n++) begin
                for (int r = 0; r < 2; r++) begin
                    run_frame(16'(32'h9E37 * (h * 40 + n * 2 + r + 1)), h, n, r[0], 1'b0, 0, 1'b0);
                end
            end
        end

        // Extreme words
        run_frame(16'hFFFF, 1, 16, 1'b1, 1'b0, 0, 1'b0);
        run_frame(16'h0000, 2, 16, 1'b1, 1'b0, 0, 1'b0);
        run_frame(16'hFFFF, 1, 1, 1'b0, 1'b0, 0, 1'b0);
        // R5 null bit high
        run_frame(16'h5A5A, 1, 16, 1'b0, 1'b1, 0, 1'b0);
        run_frame(16'h1234, 2, 3, 1'b1, 1'b1, 0, 1'b0);
        // R7 replay corruption at the lowest and highest replay bit
        run_frame(16'hC0DE, 1, 16, 1'b1, 1'b0, 1, 1'b0);
        run_frame(16'hC0DE, 1, 16, 1'b1, 1'b0, 15, 1'b0);
        // R7 corruption ignored on a short frame
        run_frame(16'hBEEF, 1, 8, 1'b1, 1'b0, 5, 1'b0);
        // R9 start strobes during a frame
        run_frame(16'h7E81, 1, 16, 1'b1, 1'b0, 0, 1'b1);
        run_frame(16'h8001, 3, 4, 1'b0, 1'b0, 0, 1'b1);

        finish_run();
    end

endmodule